// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a synthesizable, small-depth model of a pipelined synchronous SRAM that needs no idle cycle when the bus changes direction between read and write. Storage is organised as words made of equal byte lanes, 36 bits by default as four 9-bit lanes. Every control input is sampled on the rising clock edge. These inputs are three chip selects, a burst advance strobe, a hold input, a write request and one active-low write strobe per lane.

A command can load a new external address and start a four-beat burst. It can also advance an open burst to its next beat, or be held off by the hold input. The data phase of every command comes exactly one cycle after the command itself. Read data is driven in that cycle. Write data is presented in that cycle and taken at the edge that closes it. A write can be followed at once by a read of the same word. The bidirectional bus is split into an input, an output and an output-valid flag. A separate output-disable input, which is not clocked, can mask the output-valid flag at any time.

Top module: `zbt_sram`

## Requirements
- R1: When `burst_adv` is 0 and any select is inactive (`sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1), the data phase that follows is idle with `rdata_en`=0. Any open burst is closed, so later advance cycles stay idle until a new load.
- R2: When `burst_adv` is 0, all selects are active and `wr_n`=1, a read starts at `addr`. In the next cycle `rdata` holds that word and `rdata_en`=1, provided `out_off`=0.
- R3: When `burst_adv` is 0, all selects are active and `wr_n`=0, a write starts at `addr`. The word on `wdata` in the following cycle is stored, but only in the lanes whose strobe in `lane_wr_n` was 0. Lane i is bits [9i+8:9i], so lane 0 is bits 8:0 and lane 2 is bits 26:18.
- R4: A write whose strobes are all 1 is an abort. The addressed word keeps its old value and `rdata_en` stays 0.
- R5: With `burst_adv`=1 and an open burst, the beat offset in the two low address bits steps by one and wraps modulo 4. The upper bits keep the value loaded at the start of the burst. The beat repeats the read or write kind of the burst, and for a write beat `lane_wr_n` alone selects the lanes.
- R6: `hold`=1 freezes the whole pipeline. A read data phase keeps `rdata` and `rdata_en` unchanged, and the address and burst inputs are ignored.
- R7: During a held write data phase, `wdata` is ignored. The word is stored from `wdata` at the next edge with `hold`=0.
- R8: `out_off`=1 forces `rdata_en` to 0 at once, with no clock edge needed. A read made while it is 1 (a dummy read) still advances the burst address.
- R9: A read issued in the cycle right after a write to the same address returns the newly written lanes, with no idle cycle between them.
- R10: While `rst_n` is 0, and after it is released, `rdata_en` is 0 until a read is issued. Reset clears only the control pipeline, not the storage.
- R11: A write data phase never sets `rdata_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 0 loads a new address, 1 advances the open burst |
| hold | input | 1 | 1 stalls the whole pipeline for this edge |
| wr_n | input | 1 | 0 requests a write on a load cycle |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | AW | External word address |
| out_off | input | 1 | Asynchronous output disable |
| wdata | input | LANES*LANE_W | Write data for the current data phase |
| rdata | output | LANES*LANE_W | Read data for the current data phase |
| rdata_en | output | 1 | Output valid; low means the bus is released |

## Verification
The bench checks the lane mask by writing two lanes over a known word. A design with a wrong lane order or mask would change the wrong bits. It also issues a read directly after a write to the same word, which returns stale data if the forwarding path is missing. A burst started at beat offset 2 must read the beats in the order 2, 3, 0, 1. A carry into the upper address bits, or a failure to wrap, would show up there as the wrong word. Held cycles are placed after both reads and writes. A design that lets `hold` through would change `rdata`, or would store the junk word driven during the held write phase. Random stimulus also mixes in dummy reads, write aborts and advance cycles after a deselect. These catch an address that stops advancing, an abort that corrupts memory, or a burst that comes back to life after being closed.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Kind of operation carried by a pipeline slot.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Width of the wrapping beat offset inside a burst (four beats).
  localparam int BEAT_W = 2;

endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             burst_adv,
  input  logic             sel_ok,
  input  logic             wr_req,
  input  logic [LANES-1:0] lane_req,
  input  logic [AW-1:0]    ext_addr,
  output op_e              cmd_op,
  output logic [AW-1:0]    cmd_addr,
  output logic [LANES-1:0] cmd_lanes
);

  localparam int HI_W = AW - BEAT_W;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [HI_W-1:0]   base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  // Next-state: burst bookkeeping and the command issued at this edge.
  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    beat_d = beat_q;
    if (!burst_adv) begin
      if (sel_ok) begin
        act_d  = 1'b1;
        wr_d   = wr_req;
        base_d = ext_addr[AW-1:BEAT_W];
        beat_d = ext_addr[BEAT_W-1:0];
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      beat_d = beat_q + 1'b1;
    end

    cmd_addr  = {base_d, beat_d};
    cmd_op    = OP_NONE;
    cmd_lanes = '0;
    if (act_d) begin
      cmd_op    = wr_d ? OP_WRITE : OP_READ;
      cmd_lanes = wr_d ? lane_req : '0;
    end
  end

  // State register, advanced only on enabled edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (ce) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/zbt_data_stage.sv
module zbt_data_stage
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  op_e                     cmd_op,
  input  logic [AW-1:0]           cmd_addr,
  input  logic [LANES-1:0]        cmd_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES*LANE_W-1:0] mem_rdata,
  output logic [LANES-1:0]        commit_lanes,
  output logic [AW-1:0]           commit_addr,
  output logic [LANES*LANE_W-1:0] rd_word,
  output logic                    st_read
);

  localparam int WORD_W = LANES * LANE_W;

  op_e               st_op_q, st_op_d;
  logic [AW-1:0]     st_addr_q, st_addr_d;
  logic [LANES-1:0]  st_lanes_q, st_lanes_d;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic [WORD_W-1:0] fwd_word;
  logic              same_addr;

  // The data phase of a write ends at the next enabled edge.
  assign commit_lanes = (ce && st_op_q == OP_WRITE) ? st_lanes_q : '0;
  assign commit_addr  = st_addr_q;
  assign same_addr    = (st_addr_q == cmd_addr);

  // Per-lane forwarding of a write that commits on the same edge as a read.
  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd_word[l*LANE_W +: LANE_W] =
      (commit_lanes[l] && same_addr) ? wr_data[l*LANE_W +: LANE_W]
                                     : mem_rdata[l*LANE_W +: LANE_W];
  end

  always_comb begin
    st_op_d    = cmd_op;
    st_addr_d  = cmd_addr;
    st_lanes_d = cmd_lanes;
    rd_d       = (cmd_op == OP_READ) ? fwd_word : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_op_q    <= OP_NONE;
      st_addr_q  <= '0;
      st_lanes_q <= '0;
      rd_q       <= '0;
    end else if (ce) begin
      st_op_q    <= st_op_d;
      st_addr_q  <= st_addr_d;
      st_lanes_q <= st_lanes_d;
      rd_q       <= rd_d;
    end
  end

  assign rd_word = rd_q;
  assign st_read = (st_op_q == OP_READ);

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_lanes,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  // One independent storage column per byte lane; no reset on contents.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[l]) begin
        cells[waddr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_adv,
  input  logic              hold,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [AW-1:0]     addr,
  input  logic              out_off,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_en
);

  logic              ce;
  logic              sel_ok;
  op_e               cmd_op;
  logic [AW-1:0]     cmd_addr;
  logic [LANES-1:0]  cmd_lanes;
  logic [LANES-1:0]  commit_lanes;
  logic [AW-1:0]     commit_addr;
  logic [WORD_W-1:0] mem_rdata;
  logic              st_read;

  assign ce     = ~hold;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  zbt_burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .burst_adv (burst_adv),
    .sel_ok    (sel_ok),
    .wr_req    (~wr_n),
    .lane_req  (~lane_wr_n),
    .ext_addr  (addr),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_lanes (cmd_lanes)
  );

  zbt_data_stage #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce           (ce),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_lanes    (cmd_lanes),
    .wr_data      (wdata),
    .mem_rdata    (mem_rdata),
    .commit_lanes (commit_lanes),
    .commit_addr  (commit_addr),
    .rd_word      (rdata),
    .st_read      (st_read)
  );

  zbt_lane_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .we_lanes (commit_lanes),
    .waddr    (commit_addr),
    .wdata    (wdata),
    .raddr    (cmd_addr),
    .rdata    (mem_rdata)
  );

  // Output disable acts without a clock edge.
  assign rdata_en = st_read & ~out_off;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              burst_adv,
  input logic              hold,
  input logic              wr_n,
  input logic              out_off,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_en
);

  logic desel, load_wr;
  assign desel   = sel_a_n | ~sel_b | sel_c_n;
  assign load_wr = ~sel_a_n & sel_b & ~sel_c_n & ~wr_n;

  // R1: a deselect on a load cycle leaves the next data phase idle.
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !burst_adv && desel) |=> !rdata_en);

  // R6: a held edge keeps the output word and its valid flag.
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !out_off) |=> ($stable(rdata) && (!out_off -> $stable(rdata_en))));

  // R8: output disable masks the valid flag.
  a_r8_out_off_masks: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> !rdata_en);

  // R10: the bus is released as reset ends.
  a_r10_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !rdata_en);

  // R11: a write data phase never drives the bus.
  a_r11_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !burst_adv && load_wr) |=> !rdata_en);

endmodule

bind zbt_sram zbt_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .burst_adv (burst_adv),
  .hold      (hold),
  .wr_n      (wr_n),
  .out_off   (out_off),
  .rdata     (rdata),
  .rdata_en  (rdata_en)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;

  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int W     = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_a_n, sel_b, sel_c_n, burst_adv, hold, wr_n, out_off;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata, rdata;
  logic          rdata_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  zbt_sram dut (.*);

  // Reference state derived from the requirements.
  logic [W-1:0]  ref_mem [DEPTH];
  bit            m_act, m_wr;
  logic [5:0]    m_base;
  logic [1:0]    m_off;
  int            p_op;          // 0 idle, 1 read, 2 write
  logic [AW-1:0] p_addr;
  logic [3:0]    p_lanes;
  logic [W-1:0]  p_rd;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd36();
    return W'({$urandom(), $urandom()});
  endfunction

  task automatic cyc(input bit h, input bit adv, input bit san, input bit sb, input bit scn,
                     input bit wn, input logic [3:0] bwn, input logic [AW-1:0] a,
                     input bit oo, input logic [W-1:0] din, input string tag);
    sel_a_n = san; sel_b = sb; sel_c_n = scn; burst_adv = adv; hold = h;
    wr_n = wn; lane_wr_n = bwn; addr = a; out_off = oo; wdata = din;
    @(posedge clk);
    if (!h) begin
      if (p_op == 2)
        for (int l = 0; l < 4; l++)
          if (p_lanes[l]) ref_mem[p_addr][l*9 +: 9] = din[l*9 +: 9];
      if (!adv) begin
        if (!san && sb && !scn) begin
          m_act = 1; m_wr = !wn; m_base = a[7:2]; m_off = a[1:0];
        end else m_act = 0;
      end else if (m_act) m_off = m_off + 2'd1;
      p_op    = m_act ? (m_wr ? 2 : 1) : 0;
      p_addr  = {m_base, m_off};
      p_lanes = (m_act && m_wr) ? ~bwn : 4'b0;
      if (p_op == 1) p_rd = ref_mem[p_addr];
    end
    @(negedge clk);
    chk(rdata_en === (p_op == 1 && !oo), tag, W'(rdata_en), W'(p_op == 1 && !oo));
    if (p_op == 1 && !oo) chk(rdata === p_rd, tag, rdata, p_rd);
  endtask

  task automatic idle(input logic [W-1:0] din);
    cyc(0, 0, 1, 1, 0, 1, 4'hF, '0, 0, din, "R1 idle");
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] old, d, junk;
    void'($urandom(32'd4242));
    rst_n = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; burst_adv = 0; hold = 0;
    wr_n = 1; lane_wr_n = '1; addr = '0; out_off = 0; wdata = '0;
    m_act = 0; m_wr = 0; m_base = '0; m_off = '0; p_op = 0; p_addr = '0; p_lanes = '0; p_rd = '0;
    repeat (3) @(negedge clk);
    chk(rdata_en === 1'b0, "R10 during reset", W'(rdata_en), '0);
    rst_n = 1;
    @(negedge clk);
    chk(rdata_en === 1'b0, "R10 after release", W'(rdata_en), '0);

    // Fill every word with full-lane write bursts.
    for (int b = 0; b < DEPTH / 4; b++) begin
      cyc(0, 0, 0, 1, 0, 0, 4'h0, AW'(b * 4), 0, rnd36(), "R3 fill");
      for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 0, 1, 4'h0, '0, 0, rnd36(), "R5 fill");
    end
    idle(rnd36());

    // R3: lanes 0 and 2 (bits 8:0 and 26:18) only.
    old = ref_mem[8]; d = rnd36();
    cyc(0, 0, 0, 1, 0, 0, 4'b1010, 8'd8, 0, '0, "R11 write no drive");
    idle(d);
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd8, 0, '0, "R2 read");
    chk(rdata === ((old & ~36'h007FC01FF) | (d & 36'h007FC01FF)), "R3 lane mask",
        rdata, (old & ~36'h007FC01FF) | (d & 36'h007FC01FF));

    // R4: abort keeps old word.
    old = ref_mem[12];
    cyc(0, 0, 0, 1, 0, 0, 4'hF, 8'd12, 0, '0, "R4 abort idle bus");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd12, 0, rnd36(), "R4 abort");
    chk(rdata === old, "R4 abort keeps word", rdata, old);

    // R9: read right after write to same word.
    d = rnd36();
    cyc(0, 0, 0, 1, 0, 0, 4'h0, 8'd20, 0, '0, "R9 write");
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd20, 0, d, "R9 read");
    chk(rdata === d, "R9 forward", rdata, d);

    // R5: burst starting at offset 2 wraps 2,3,0,1.
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd34, 0, '0, "R5 load");
    chk(rdata === ref_mem[34], "R5 beat 34", rdata, ref_mem[34]);
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 8'd0, 0, '0, "R5 adv");
    chk(rdata === ref_mem[35], "R5 beat 35", rdata, ref_mem[35]);
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 8'd0, 0, '0, "R5 adv");
    chk(rdata === ref_mem[32], "R5 wrap 32", rdata, ref_mem[32]);
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 8'd0, 0, '0, "R5 adv");
    chk(rdata === ref_mem[33], "R5 beat 33", rdata, ref_mem[33]);

    // R6: hold after a read keeps the word.
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd40, 0, '0, "R6 read");
    cyc(1, 0, 0, 1, 0, 1, 4'hF, 8'd77, 0, '0, "R6 hold");
    chk(rdata === ref_mem[40] && rdata_en === 1'b1, "R6 held data", rdata, ref_mem[40]);

    // R7: held write phase ignores wdata.
    d = rnd36(); junk = ~d;
    cyc(0, 0, 0, 1, 0, 0, 4'h0, 8'd44, 0, '0, "R7 write");
    cyc(1, 0, 0, 1, 0, 1, 4'hF, 8'd3, 0, junk, "R7 hold");
    idle(d);
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd44, 0, '0, "R7 read");
    chk(rdata === d, "R7 stored after hold", rdata, d);

    // R8: dummy read advances, output disable is asynchronous.
    cyc(0, 0, 0, 1, 0, 1, 4'hF, 8'd48, 1, '0, "R8 dummy");
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 8'd0, 0, '0, "R8 adv");
    chk(rdata === ref_mem[49], "R8 address advanced", rdata, ref_mem[49]);
    out_off = 1; #1;
    chk(rdata_en === 1'b0, "R8 async disable", W'(rdata_en), '0);
    out_off = 0; #1;
    chk(rdata_en === 1'b1, "R8 async enable", W'(rdata_en), '1);

    // R1: each select alone deselects and closes the burst.
    cyc(0, 0, 1, 1, 0, 1, 4'hF, 8'd50, 0, '0, "R1 sel_a");
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 8'd0, 0, '0, "R1 adv after deselect");
    chk(rdata_en === 1'b0, "R1 burst closed", W'(rdata_en), '0);
    cyc(0, 0, 0, 0, 0, 1, 4'hF, 8'd50, 0, '0, "R1 sel_b");
    cyc(0, 0, 0, 1, 1, 1, 4'hF, 8'd50, 0, '0, "R1 sel_c");

    // Random mix checked against the reference state.
    for (int i = 0; i < 4000; i++) begin
      bit h, adv, san, sb, scn, wn, oo;
      logic [3:0] bwn;
      h   = ($urandom_range(5) == 0);
      adv = ($urandom_range(2) != 0);
      san = ($urandom_range(9) == 0);
      sb  = ($urandom_range(9) != 0);
      scn = ($urandom_range(9) == 0);
      wn  = $urandom_range(1) != 0;
      bwn = ($urandom_range(7) == 0) ? 4'hF : 4'($urandom());
      oo  = ($urandom_range(5) == 0);
      cyc(h, adv, san, sb, scn, wn, bwn, AW'($urandom()), oo, rnd36(), "R2/R5/R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule